// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level tree of tables: one root directory, plus second-level (leaf) tables. The tables live in a word-addressed memory inside the block, and that memory has one cycle of read latency. A table-load port fills the memory. The walker then accepts one translation request at a time on a valid/ready handshake. It reads the root entry and checks its present bit. If the root entry is present, it reads the leaf entry and checks that present bit too. The walk ends in a one-cycle response that carries either a physical address or a fault code.

A store that reaches a present leaf marks the page as modified. The walker does this by writing the leaf word back with its dirty bit set, before it responds. A load leaves the leaf untouched. The response also reports the leaf's dirty bit as it stands after the walk. Software can therefore see the effect of earlier stores through the normal interface.

Both kinds of table entry use the same word layout. Bit 0 is the present flag. Bits 31:12 hold a frame number. Bit 1 is the dirty flag; it has meaning only in leaf entries.

Top module: `pt_walker`

## Requirements
- R1: After reset, `respValid` is low and `reqReady` is high.
- R2: The virtual address splits into root index = bits 31:22, leaf index = bits 21:12 and offset = bits 11:0. The root entry is at word address `ROOT_FRAME*1024 + rootIndex`. The leaf entry is at word address `(rootFrame mod MEM_FRAMES)*1024 + leafIndex`, where rootFrame is bits 31:12 of the root entry.
- R3: A load that finds a present root entry and a present leaf entry raises `respValid` in the fourth cycle after the accepting edge. In that cycle `respPaddr` = {leaf bits 31:12, offset} and `respFault` = 0.
- R4: A root entry with bit 0 clear gives `respFault` = 1 in the third cycle after acceptance. No leaf read is made, and `respPaddr` and `respDirty` are 0.
- R5: A leaf entry with bit 0 clear gives `respFault` = 2 in the fourth cycle after acceptance, with `respPaddr` and `respDirty` 0. The leaf word is not modified.
- R6: A store that finds a present leaf sets bit 1 of the stored leaf word. It responds in the fifth cycle after acceptance with `respDirty` = 1.
- R7: A load leaves the stored leaf word unchanged, and `respDirty` reports the stored bit 1.
- R8: `reqReady` is high only while the walker is idle. `reqValid` seen while busy is ignored and produces no response.
- R9: If the table-load port writes during the dirty write-back cycle, the load write takes effect and the write-back is retried one cycle later. Both words end up written, and the response is delayed by one cycle.
- R10: `respValid` is high for exactly one cycle per accepted request. The walker is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle, request taken on this edge |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = store access, 0 = load access |
| respValid | output | 1 | One-cycle response strobe |
| respPaddr | output | 32 | Physical address (0 on fault) |
| respFault | output | 2 | 0 none, 1 root absent, 2 leaf not present |
| respDirty | output | 1 | Leaf dirty bit after the walk (0 on fault) |
| tblWe | input | 1 | Table memory write enable |
| tblAddr | input | MEM_AW (12) | Table memory word address |
| tblWdata | input | 32 | Table memory write data |

## Verification
The table-load port and the walker's dirty write-back share a single write path into the table memory, so both can want it in the same cycle. The bench provokes this by timing a load-port write to a different leaf word so that it lands exactly in the write-back cycle of a store walk. It judges the outcome in three ways. The response must arrive one cycle late and still report dirty. A later load of the page written through the load port must return the new frame. A later load of the stored page must show its dirty bit set. A cycle-accurate reference model in the bench predicts every response cycle, and every busy cycle is checked for silence.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_LEAF,
    ST_CHECK,
    ST_DIRTY,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch request, clear fault
    logic rdEn;       // issue a table read
    logic rdLeaf;     // 1: leaf address, 0: root address
    logic capLeaf;    // latch leaf entry
    logic wbEn;       // write back leaf with dirty set
    logic faultRoot;  // record root-absent fault
    logic faultLeaf;  // record leaf-not-present fault
  } walkStrb_t;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_ROOT = 2'd1;
  localparam logic [1:0] FLT_LEAF = 2'd2;

endpackage

// File: rtl/ptw_mem.sv
module ptw_mem #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgData,
  input  logic          wbEn,
  input  logic [AW-1:0] wbAddr,
  input  logic [DW-1:0] wbData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  // load port has priority on the single write path
  always_comb begin
    wrEn   = cfgWe | wbEn;
    wrAddr = cfgWe ? cfgAddr : wbAddr;
    wrData = cfgWe ? cfgData : wbData;
  end

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= store[rdAddr];
  end

  // R9
  single_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> !cfgWe)
    else $error("walker write-back collided with load port write");

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int OFFS_W     = 12,
  parameter int MEM_FRAMES = 4,
  parameter int ROOT_FRAME = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  walkStrb_t              strb,
  input  logic [2*(OFFS_W-2)+OFFS_W-1:0] reqVaddr,
  input  logic                   reqWrite,
  input  logic [31:0]            rdData,
  output logic [$clog2(MEM_FRAMES)+OFFS_W-3:0] rdAddr,
  output logic [$clog2(MEM_FRAMES)+OFFS_W-3:0] wbAddr,
  output logic [31:0]            wbData,
  output logic                   entryPresent,
  output logic                   isWrite,
  output logic [31:0]            paddr,
  output logic [1:0]             faultCode,
  output logic                   dirtyOut
);
  localparam int IDX_W = OFFS_W - 2;
  localparam int VA_W  = 2 * IDX_W + OFFS_W;
  localparam int FB    = $clog2(MEM_FRAMES);
  localparam int AW    = FB + IDX_W;
  localparam logic [FB-1:0] ROOT_SEL = FB'(ROOT_FRAME);

  logic [VA_W-1:0]  vaReg;
  logic             wrReg;
  logic [31:0]      leafReg;
  logic [1:0]       faultReg;
  logic [AW-1:0]    leafAddrReg;

  logic [IDX_W-1:0]  rootIdx;
  logic [IDX_W-1:0]  leafIdx;
  logic [OFFS_W-1:0] pgOffset;
  logic [AW-1:0]     rootWord;
  logic [AW-1:0]     leafWord;

  always_comb begin
    rootIdx  = vaReg[VA_W-1 -: IDX_W];
    leafIdx  = vaReg[OFFS_W +: IDX_W];
    pgOffset = vaReg[OFFS_W-1:0];
    rootWord = {ROOT_SEL, rootIdx};
    leafWord = {rdData[OFFS_W +: FB], leafIdx};
    rdAddr   = strb.rdLeaf ? leafWord : rootWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg       <= '0;
      wrReg       <= 1'b0;
      leafReg     <= '0;
      faultReg    <= FLT_NONE;
      leafAddrReg <= '0;
    end else begin
      if (strb.capReq) begin
        vaReg    <= reqVaddr;
        wrReg    <= reqWrite;
        faultReg <= FLT_NONE;
        leafReg  <= '0;
      end
      if (strb.rdEn && strb.rdLeaf) leafAddrReg <= leafWord;
      if (strb.capLeaf)             leafReg     <= rdData;
      if (strb.wbEn)                leafReg[1]  <= 1'b1;
      if (strb.faultRoot)           faultReg    <= FLT_ROOT;
      if (strb.faultLeaf)           faultReg    <= FLT_LEAF;
    end
  end

  always_comb begin
    entryPresent = rdData[0];
    isWrite      = wrReg;
    wbAddr       = leafAddrReg;
    wbData       = {leafReg[31:2], 1'b1, leafReg[0]};
    faultCode    = faultReg;
    paddr        = (faultReg != FLT_NONE) ? 32'd0
                                          : {leafReg[31:OFFS_W], pgOffset};
    dirtyOut     = (faultReg != FLT_NONE) ? 1'b0 : leafReg[1];
  end

  // R4
  fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultReg != 2'd3)
    else $error("illegal fault code");

  // R6
  wb_only_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wbEn |-> wrReg)
    else $error("dirty write-back on a load access");

  // R5
  leaf_fault_after_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.faultLeaf |-> !strb.capLeaf && !strb.wbEn)
    else $error("leaf fault together with leaf capture");

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      entryPresent,
  input  logic      isWrite,
  input  logic      cfgWe,
  output walkStrb_t strb,
  output logic      reqReady,
  output logic      respValid
);
  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capReq = 1'b1;
          stateNext   = ST_ROOT;
        end
      end
      ST_ROOT: begin
        strb.rdEn = 1'b1;
        stateNext = ST_LEAF;
      end
      ST_LEAF: begin
        if (!entryPresent) begin
          strb.faultRoot = 1'b1;
          stateNext      = ST_FAULT;
        end else begin
          strb.rdEn   = 1'b1;
          strb.rdLeaf = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!entryPresent) begin
          strb.faultLeaf = 1'b1;
          stateNext      = ST_FAULT;
        end else begin
          strb.capLeaf = 1'b1;
          stateNext    = isWrite ? ST_DIRTY : ST_DONE;
        end
      end
      ST_DIRTY: begin
        if (!cfgWe) begin
          strb.wbEn = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady  = (state == ST_IDLE);
    respValid = (state == ST_DONE) || (state == ST_FAULT);
  end

  // R4
  root_absent_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAF && !entryPresent) |-> !strb.rdEn)
    else $error("leaf read issued after absent root entry");

  // R10
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady)
    else $error("response strobe longer than one cycle");

  // R9
  wb_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIRTY && cfgWe) |=> (state == ST_DIRTY))
    else $error("write-back did not yield to load port");

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |-> !strb.capReq)
    else $error("request captured while busy");

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int OFFS_W     = 12,
  parameter int MEM_FRAMES = 4,
  parameter int ROOT_FRAME = 0,
  localparam int IDX_W     = OFFS_W - 2,
  localparam int MEM_AW    = $clog2(MEM_FRAMES) + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqVaddr,
  input  logic              reqWrite,
  output logic              respValid,
  output logic [31:0]       respPaddr,
  output logic [1:0]        respFault,
  output logic              respDirty,
  input  logic              tblWe,
  input  logic [MEM_AW-1:0] tblAddr,
  input  logic [31:0]       tblWdata
);
  walkStrb_t         strb;
  logic              entryPresent;
  logic              isWrite;
  logic [31:0]       rdData;
  logic [MEM_AW-1:0] rdAddr;
  logic [MEM_AW-1:0] wbAddr;
  logic [31:0]       wbData;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .entryPresent(entryPresent),
    .isWrite     (isWrite),
    .cfgWe       (tblWe),
    .strb        (strb),
    .reqReady    (reqReady),
    .respValid   (respValid)
  );

  ptw_datapath #(
    .OFFS_W    (OFFS_W),
    .MEM_FRAMES(MEM_FRAMES),
    .ROOT_FRAME(ROOT_FRAME)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .rdData      (rdData),
    .rdAddr      (rdAddr),
    .wbAddr      (wbAddr),
    .wbData      (wbData),
    .entryPresent(entryPresent),
    .isWrite     (isWrite),
    .paddr       (respPaddr),
    .faultCode   (respFault),
    .dirtyOut    (respDirty)
  );

  ptw_mem #(
    .AW(MEM_AW),
    .DW(32)
  ) u_mem (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (strb.rdEn),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cfgWe  (tblWe),
    .cfgAddr(tblAddr),
    .cfgData(tblWdata),
    .wbEn   (strb.wbEn),
    .wbAddr (wbAddr),
    .wbData (wbData)
  );

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam int MEM_FRAMES = 4;
  localparam int ROOT_FRAME = 0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        respValid;
  logic [31:0] respPaddr;
  logic [1:0]  respFault;
  logic        respDirty;
  logic        tblWe = 1'b0;
  logic [11:0] tblAddr = '0;
  logic [31:0] tblWdata = '0;

  int applied = 0;
  int miscmp  = 0;
  bit runDone = 1'b0;
  logic [31:0] mdl [int];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .respValid(respValid),
    .respPaddr(respPaddr), .respFault(respFault), .respDirty(respDirty),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblWdata(tblWdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input int addr, input logic [31:0] data);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = 12'(addr); tblWdata = data;
    mdl[addr] = data;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  function automatic logic [31:0] rdMdl(input int a);
    return mdl.exists(a) ? mdl[a] : 32'd0;
  endfunction

  // behavioural reference for one walk
  task automatic walk(input logic [31:0] va, input bit wr, input bit stall, input bit poke);
    int rAddr, lAddr, lat;
    logic [31:0] re, le, expPa;
    logic [1:0] expF;
    bit expD;
    int stAddr;
    rAddr = ROOT_FRAME * 1024 + int'(va[31:22]);
    re = rdMdl(rAddr);
    lAddr = 0; expPa = 0; expD = 0; stAddr = 1024 + 1;
    if (!re[0]) begin
      expF = 2'd1; lat = 3;
    end else begin
      lAddr = (int'(re[31:12]) % MEM_FRAMES) * 1024 + int'(va[21:12]);
      le = rdMdl(lAddr);
      if (!le[0]) begin
        expF = 2'd2; lat = 4;
      end else begin
        expF = 2'd0;
        expPa = {le[31:12], va[11:0]};
        expD = wr ? 1'b1 : le[1];
        lat = wr ? (stall ? 6 : 5) : 4;
      end
    end
    @(negedge clk);
    chk("R8 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(posedge clk);
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      reqValid = poke && (c < lat);
      reqVaddr = ~va;
      reqWrite = 1'b0;
      if (stall && c == 4) begin
        tblWe = 1'b1; tblAddr = 12'(stAddr); tblWdata = 32'h0BEEF001;
        mdl[stAddr] = 32'h0BEEF001;
      end
      if (stall && c == 5) tblWe = 1'b0;
      if (c < lat) begin
        chk("R10 no early response", 32'(respValid), 32'd0);
        chk("R8 busy not ready", 32'(reqReady), 32'd0);
      end else begin
        chk("R3 response cycle", 32'(respValid), 32'd1);
        chk("R3 paddr", respPaddr, expPa);
        chk(expF == 1 ? "R4 fault" : (expF == 2 ? "R5 fault" : "R3 fault"),
            32'(respFault), 32'(expF));
        chk(wr ? "R6 dirty" : "R7 dirty", 32'(respDirty), 32'(expD));
      end
    end
    if (wr && expF == 0) mdl[lAddr] = le | 32'd2;
    @(negedge clk);
    chk("R10 single pulse", 32'(respValid), 32'd0);
    chk("R10 idle after response", 32'(reqReady), 32'd1);
    @(negedge clk);
    chk("R8 no response to ignored request", 32'(respValid), 32'd0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 respValid reset", 32'(respValid), 32'd0);
    chk("R1 reqReady reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    // R2 tables: root in frame 0, leaf tables in frames 1 and 2
    load(12'h000, 32'h00001001);
    load(12'h3FF, 32'h00002001);
    load(12'h005, 32'h00003000);
    load(12'h001, 32'h00006001);   // frame 6 folds onto frame 2
    load(12'h400, 32'hABCDE001);
    load(12'h401, 32'h11111001);
    load(12'h7FF, 32'h12345003);
    load(12'h410, 32'h55555000);
    load(12'hA00, 32'hFEDCB001);
    load(12'hBFF, 32'h00777001);
    // R3 / R2 read hits
    walk(32'h00000123, 1'b0, 1'b0, 1'b0);
    walk(32'h003FFFFF, 1'b0, 1'b0, 1'b0);
    // R5 leaf absent
    walk(32'h00010000, 1'b0, 1'b0, 1'b0);
    walk(32'h00010ABC, 1'b1, 1'b0, 1'b0);
    // R4 root absent
    walk(32'h01400000, 1'b0, 1'b0, 1'b0);
    walk(32'h01412345, 1'b1, 1'b0, 1'b0);
    // R6 store then load of the same page
    walk(32'hFFE000AB, 1'b1, 1'b0, 1'b0);
    walk(32'hFFE00FFF, 1'b0, 1'b0, 1'b0);
    // R7 load keeps page clean
    walk(32'h00000456, 1'b0, 1'b0, 1'b0);
    walk(32'h00000457, 1'b0, 1'b0, 1'b0);
    // R2 frame folding onto frame 2
    walk(32'h00600010, 1'b0, 1'b0, 1'b0);
    // R8 request held high while busy
    walk(32'h003FF001, 1'b0, 1'b0, 1'b1);
    walk(32'hFFFFF001, 1'b0, 1'b0, 1'b1);
    // R9 load port collides with write-back
    walk(32'hFFFFF456, 1'b1, 1'b1, 1'b0);
    walk(32'h00001789, 1'b0, 1'b0, 1'b0);
    walk(32'hFFFFF457, 1'b0, 1'b0, 1'b0);
    runDone = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!runDone) begin
      miscmp++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

endmodule